// File: doc/BRIEF.md
# Clock Frequency Accuracy Monitor

This block tells software whether a monitored clock runs at the expected rate. It counts cycles of the monitored clock (the block's own `clk`) between consecutive valid edges of a reference signal. The reference is either an asynchronous external pin or an internally divided clock. Each completed interval is stored in a capture register and compared against an inclusive window set by an upper and a lower limit. Every completed interval raises a measurement-done flag. An interval that falls outside the window also raises an out-of-range flag. Each flag can drive its own interrupt line.

Software programs the two limits, picks the reference source and the edge type, and then sets the enable bit. The first valid edge after enabling only starts the counter; every later edge closes one interval and starts the next. Software clears the flags by writing ones to the status register. Clearing the enable bit stops the measurement and zeroes the counter.

Top module: `clk_freq_mon`

## Requirements
- R1: After reset the control, interrupt-enable, status and capture registers read zero and both interrupt outputs are low.
- R2: Setting the enable bit (control bit 0) arms the block. The first valid reference edge after that only starts the counter from zero. It changes neither the capture register nor any flag.
- R3: On every later valid edge the capture register receives the count, which equals the number of monitored-clock cycles between the two edges minus one. The counter then restarts from zero.
- R4: A capture with lower limit <= value <= upper limit sets the done flag (status bit 0) and leaves the out-of-range flag (status bit 1) unchanged.
- R5: A capture above the upper limit or below the lower limit sets both the done flag and the out-of-range flag. Both limits are inclusive.
- R6: Control bits 3:2 choose the valid edge: 00 rising, 01 falling, 10 or 11 both edges.
- R7: Writing the status register clears the done flag where data bit 0 is 1 and the out-of-range flag where data bit 1 is 1. Zero bits leave their flag unchanged.
- R8: `irq_end_o` is the done flag gated by interrupt-enable bit 0. `irq_err_o` is the out-of-range flag gated by interrupt-enable bit 1.
- R9: Clearing the enable bit stops the measurement and zeroes the counter, and keeps both flags and the capture register. Reference edges that arrive while disabled have no effect. A new measurement after re-enabling waits again for a first edge.
- R10: Control bit 1 selects the reference: 0 the pin input, 1 the internal input. The input that is not selected has no effect.
- R11: The counter stops at all ones (FFFFh for the default 16-bit width) instead of wrapping.
- R12: Register addresses: 0 control, 1 upper limit, 2 lower limit, 3 status (write-one-to-clear), 4 interrupt enable, 5 capture (read only). The limits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitored clock; clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pin_i | input | 1 | External reference, asynchronous |
| ref_int_i | input | 1 | Internal divided reference |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for `bus_addr_i` |
| irq_end_o | output | 1 | Measurement-done interrupt |
| irq_err_o | output | 1 | Out-of-range interrupt |

## Verification
The assertions assume that software changes the source and edge selection only while measurement is disabled, because a switch while enabled can create a false edge. They also assume that reference pulses last several monitored cycles, so that the synchronizer sees every level. The bench always writes control with the enable bit clear before it changes the configuration. It holds every reference level for at least three cycles and drives the reference on falling clock edges, which gives exact, repeatable interval lengths.

// File: rtl/clk_freq_mon_pkg.sv
package clk_freq_mon_pkg;
   typedef enum logic [1:0] {
      EDG_RISE    = 2'b00,
      EDG_FALL    = 2'b01,
      EDG_ANY     = 2'b10,
      EDG_ANY_ALT = 2'b11
   } edge_mode_e;

   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_UPPER = 3'd1;
   localparam logic [2:0] A_LOWER = 3'd2;
   localparam logic [2:0] A_STAT  = 3'd3;
   localparam logic [2:0] A_IEN   = 3'd4;
   localparam logic [2:0] A_CAPT  = 3'd5;

   localparam int CTRL_EN  = 0;
   localparam int CTRL_SEL = 1;
   localparam int CTRL_EDG = 2;
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad
      $error("cfm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cfm_edge.sv
module cfm_edge
   import clk_freq_mon_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_i,
   input  edge_mode_e mode_i,
   output logic       pulse_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   logic rise, fall;
   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;

   always_comb begin
      case (mode_i)
         EDG_RISE: pulse_o = rise;
         EDG_FALL: pulse_o = fall;
         default:  pulse_o = rise | fall;
      endcase
   end
endmodule

// File: rtl/cfm_counter.sv
module cfm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             edge_i,
   input  logic [CNT_W-1:0] upper_i,
   input  logic [CNT_W-1:0] lower_i,
   output logic             run_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cap_o,
   output logic             cap_stb_o,
   output logic             cap_bad_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o     <= 1'b0;
         cnt_o     <= '0;
         cap_o     <= '0;
         cap_stb_o <= 1'b0;
         cap_bad_o <= 1'b0;
      end else if (!en_i) begin
         run_o     <= 1'b0;
         cnt_o     <= '0;
         cap_stb_o <= 1'b0;
      end else begin
         cap_stb_o <= 1'b0;
         if (edge_i) begin
            cnt_o <= '0;
            if (run_o) begin
               cap_o     <= cnt_o;
               cap_stb_o <= 1'b1;
               cap_bad_o <= (cnt_o > upper_i) || (cnt_o < lower_i);
            end else begin
               run_o <= 1'b1;
            end
         end else if (run_o && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clk_freq_mon.sv
module clk_freq_mon
   import clk_freq_mon_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_pin_i,
   input  logic             ref_int_i,
   input  logic             bus_wr_i,
   input  logic [2:0]       bus_addr_i,
   input  logic [CNT_W-1:0] bus_wdata_i,
   output logic [CNT_W-1:0] bus_rdata_o,
   output logic             irq_end_o,
   output logic             irq_err_o
);
   localparam int N_REF = 2;

   if (CNT_W < 4) begin : g_bad_w
      $error("clk_freq_mon: CNT_W must be at least 4");
   end

   // configuration registers
   logic             meas_en, ref_sel;
   logic [1:0]       edge_sel, ien_q;
   logic [CNT_W-1:0] upper_q, lower_q;
   logic             flag_end, flag_err;

   // datapath
   logic [N_REF-1:0] ref_raw, ref_syn;
   logic             ref_lvl, ref_edge, cnt_run, cap_stb, cap_bad;
   logic [CNT_W-1:0] cnt_val, cap_val;

   assign ref_raw = {ref_int_i, ref_pin_i};

   for (genvar g = 0; g < N_REF; g++) begin : g_sync
      cfm_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (ref_raw[g]),
         .q_o   (ref_syn[g])
      );
   end

   assign ref_lvl = ref_sel ? ref_syn[1] : ref_syn[0];

   cfm_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (ref_lvl),
      .mode_i  (edge_mode_e'(edge_sel)),
      .pulse_o (ref_edge)
   );

   cfm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (meas_en),
      .edge_i    (ref_edge),
      .upper_i   (upper_q),
      .lower_i   (lower_q),
      .run_o     (cnt_run),
      .cnt_o     (cnt_val),
      .cap_o     (cap_val),
      .cap_stb_o (cap_stb),
      .cap_bad_o (cap_bad)
   );

   logic wr_ctrl, wr_stat;
   assign wr_ctrl = bus_wr_i && bus_addr_i == A_CTRL;
   assign wr_stat = bus_wr_i && bus_addr_i == A_STAT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meas_en  <= 1'b0;
         ref_sel  <= 1'b0;
         edge_sel <= 2'b00;
         upper_q  <= '0;
         lower_q  <= '0;
         ien_q    <= 2'b00;
      end else if (bus_wr_i) begin
         if (wr_ctrl) begin
            meas_en  <= bus_wdata_i[CTRL_EN];
            ref_sel  <= bus_wdata_i[CTRL_SEL];
            edge_sel <= bus_wdata_i[CTRL_EDG+1:CTRL_EDG];
         end
         if (bus_addr_i == A_UPPER) upper_q <= bus_wdata_i;
         if (bus_addr_i == A_LOWER) lower_q <= bus_wdata_i;
         if (bus_addr_i == A_IEN)   ien_q   <= bus_wdata_i[1:0];
      end
   end

   // status flags: a new capture wins over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_end <= 1'b0;
         flag_err <= 1'b0;
      end else begin
         if (cap_stb)                         flag_end <= 1'b1;
         else if (wr_stat && bus_wdata_i[0])  flag_end <= 1'b0;
         if (cap_stb && cap_bad)              flag_err <= 1'b1;
         else if (wr_stat && bus_wdata_i[1])  flag_err <= 1'b0;
      end
   end

   assign irq_end_o = flag_end & ien_q[0];
   assign irq_err_o = flag_err & ien_q[1];

   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         A_CTRL:  bus_rdata_o[3:0] = {edge_sel, ref_sel, meas_en};
         A_UPPER: bus_rdata_o = upper_q;
         A_LOWER: bus_rdata_o = lower_q;
         A_STAT:  bus_rdata_o[1:0] = {flag_err, flag_end};
         A_IEN:   bus_rdata_o[1:0] = ien_q;
         A_CAPT:  bus_rdata_o = cap_val;
         default: bus_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/clk_freq_mon_chk.sv
module clk_freq_mon_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             meas_en,
   input logic             cnt_run,
   input logic             ref_edge,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CNT_W-1:0] cap_val,
   input logic             flag_end,
   input logic             flag_err,
   input logic             irq_end_o,
   input logic             irq_err_o
);
   localparam logic [CNT_W-1:0] ALL1 = '1;

   AST_START_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_run) |-> $stable(cap_val)); // R2
   AST_CAPTURE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_val) |-> $past(ref_edge && cnt_run && meas_en)); // R3
   AST_ERR_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_err) |-> flag_end); // R5
   AST_IRQ_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_end_o |-> flag_end); // R8
   AST_IRQ_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err_o |-> flag_err); // R8
   AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_en |=> (cnt_val == '0 && !cnt_run)); // R9
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_en && cnt_run && !ref_edge && cnt_val == ALL1) |=> cnt_val == ALL1); // R11
endmodule

bind clk_freq_mon clk_freq_mon_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .meas_en   (meas_en),
   .cnt_run   (cnt_run),
   .ref_edge  (ref_edge),
   .cnt_val   (cnt_val),
   .cap_val   (cap_val),
   .flag_end  (flag_end),
   .flag_err  (flag_err),
   .irq_end_o (irq_end_o),
   .irq_err_o (irq_err_o)
);

// File: tb/clk_freq_mon_bench.sv
`timescale 1ns/1ps
module clk_freq_mon_bench;
   localparam int W = 16;
   localparam logic [2:0] A_CTRL = 3'd0, A_UPPER = 3'd1, A_LOWER = 3'd2,
                          A_STAT = 3'd3, A_IEN = 3'd4, A_CAPT = 3'd5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ref_pin = 1'b0, ref_int = 1'b0;
   logic bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [W-1:0] bus_wdata = '0, bus_rdata;
   logic irq_end, irq_err;
   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clk_freq_mon u_clk_freq_mon (
      .clk(clk), .rst_n(rst_n), .ref_pin_i(ref_pin), .ref_int_i(ref_int),
      .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .irq_end_o(irq_end), .irq_err_o(irq_err));

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
      @(negedge clk); bus_addr = a; #1; v = bus_rdata;
   endtask

   // n periods of (hi high, lo low) on the chosen reference input
   task automatic drive(input bit use_int, input int hi, input int lo, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); if (use_int) ref_int = 1'b1; else ref_pin = 1'b1;
         repeat (hi - 1) @(negedge clk);
         @(negedge clk); if (use_int) ref_int = 1'b0; else ref_pin = 1'b0;
         repeat (lo - 1) @(negedge clk);
      end
   endtask

   task automatic settle(); repeat (8) @(negedge clk); endtask

   task automatic setup(input logic [W-1:0] up, input logic [W-1:0] lo,
                        input logic [1:0] ien, input logic [3:0] cfg);
      wr(A_CTRL, '0); wr(A_STAT, 16'h3);
      wr(A_UPPER, up); wr(A_LOWER, lo); wr(A_IEN, {14'd0, ien});
      wr(A_CTRL, {12'd0, cfg[3:1], 1'b1});
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      rd(A_CTRL, v); check("R1 ctrl", v, 0);
      rd(A_STAT, v); check("R1 status", v, 0);
      rd(A_CAPT, v); check("R1 capture", v, 0);
      rd(A_IEN, v);  check("R1 ien", v, 0);
      check("R1 irqs", {14'd0, irq_err, irq_end}, 0);
   endtask

   task automatic t_window();
      logic [W-1:0] v;
      setup(20, 10, 2'b00, 4'b0000);
      rd(A_UPPER, v); check("R12 upper", v, 20);
      rd(A_LOWER, v); check("R12 lower", v, 10);
      drive(0, 5, 11, 4); settle();
      rd(A_CAPT, v); check("R3 capture period16", v, 15);
      rd(A_STAT, v); check("R4 in window", v, 16'h1);
      check("R8 end irq masked", {15'd0, irq_end}, 0);
      wr(A_IEN, 16'h1); @(negedge clk);
      check("R8 end irq enabled", {15'd0, irq_end}, 1);
      wr(A_STAT, 16'h0); rd(A_STAT, v); check("R7 zero write", v, 16'h1);
      wr(A_STAT, 16'h2); rd(A_STAT, v); check("R7 err bit keeps end", v, 16'h1);
      wr(A_STAT, 16'h1); rd(A_STAT, v); check("R7 clear end", v, 16'h0);
   endtask

   task automatic t_outside();
      logic [W-1:0] v;
      setup(20, 10, 2'b10, 4'b0000);
      drive(0, 5, 25, 3); settle();
      rd(A_CAPT, v); check("R3 capture period30", v, 29);
      rd(A_STAT, v); check("R5 above upper", v, 16'h3);
      check("R8 irqs", {14'd0, irq_err, irq_end}, 16'h2);
      wr(A_STAT, 16'h1); rd(A_STAT, v); check("R7 end cleared only", v, 16'h2);
      wr(A_STAT, 16'h2); rd(A_STAT, v); check("R7 err cleared", v, 16'h0);
      setup(20, 10, 2'b00, 4'b0000);
      drive(0, 3, 3, 3); settle();
      rd(A_STAT, v); check("R5 below lower", v, 16'h3);
      setup(20, 10, 2'b00, 4'b0000);
      drive(0, 5, 16, 3); settle();
      rd(A_STAT, v); check("R5 upper inclusive", v, 16'h1);
      setup(20, 10, 2'b00, 4'b0000);
      drive(0, 4, 7, 3); settle();
      rd(A_CAPT, v); check("R3 capture period11", v, 10);
      rd(A_STAT, v); check("R5 lower inclusive", v, 16'h1);
   endtask

   task automatic t_first_edge();
      logic [W-1:0] v, prev;
      rd(A_CAPT, prev);
      setup(20, 10, 2'b00, 4'b0000);
      repeat (50) @(negedge clk);
      drive(0, 4, 30, 1); settle();
      rd(A_STAT, v); check("R2 first edge no flag", v, 0);
      rd(A_CAPT, v); check("R2 first edge no capture", v, prev);
   endtask

   task automatic t_disable();
      logic [W-1:0] v;
      setup(20, 5, 2'b00, 4'b0000);
      drive(0, 4, 6, 2); settle();
      rd(A_CAPT, v); check("R3 capture period10", v, 9);
      wr(A_CTRL, '0);
      rd(A_STAT, v); check("R9 flag kept", v, 16'h1);
      wr(A_STAT, 16'h3);
      drive(0, 4, 12, 3); settle();
      rd(A_STAT, v); check("R9 disabled no flag", v, 0);
      rd(A_CAPT, v); check("R9 disabled capture kept", v, 9);
      wr(A_CTRL, 16'h1);
      repeat (40) @(negedge clk);
      drive(0, 4, 16, 2); settle();
      rd(A_CAPT, v); check("R9 restart fresh", v, 19);
   endtask

   task automatic t_edges();
      logic [W-1:0] v;
      setup(100, 0, 2'b00, 4'b0100);
      drive(0, 4, 10, 3); settle();
      rd(A_CAPT, v); check("R6 falling", v, 13);
      setup(100, 0, 2'b00, 4'b1000);
      drive(0, 7, 7, 3); settle();
      rd(A_CAPT, v); check("R6 both mode10", v, 6);
      setup(100, 0, 2'b00, 4'b1100);
      drive(0, 5, 5, 3); settle();
      rd(A_CAPT, v); check("R6 both mode11", v, 4);
   endtask

   task automatic t_internal();
      logic [W-1:0] v;
      setup(100, 0, 2'b00, 4'b0010);
      drive(0, 4, 5, 4); settle();
      rd(A_STAT, v); check("R10 pin ignored", v, 0);
      drive(1, 4, 8, 3); settle();
      rd(A_CAPT, v); check("R10 internal capture", v, 11);
      rd(A_STAT, v); check("R10 internal flag", v, 16'h1);
   endtask

   task automatic t_saturate();
      logic [W-1:0] v;
      setup(16'hFFFF, 0, 2'b00, 4'b0000);
      drive(0, 3, 66000, 1);
      drive(0, 3, 6, 1); settle();
      rd(A_CAPT, v); check("R11 saturated", v, 16'hFFFF);
      rd(A_STAT, v); check("R11 max in window", v, 16'h1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_window();
      t_outside();
      t_first_edge();
      t_disable();
      t_edges();
      t_internal();
      t_saturate();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule